// File: doc/BRIEF.md
# Add/Subtract Status Flag Generator

This block sits beside a processor's adder and turns an 8-bit or 16-bit add, add-with-carry, subtract, subtract-with-borrow, increment or decrement into a result and six arithmetic condition flags: carry, half carry (out of bit 3), parity, zero, sign and overflow. The result and these flags are combinational and appear in the same cycle as the operands. A width input chooses whether the low byte or the full word takes part. In byte mode the upper operand bits are ignored.

A 16-bit status word holds the flags between operations. When the flag write enable is high, the arithmetic flags are loaded into the word on the rising clock edge. A separate load input, with its own enable, writes three held control bits: trap, interrupt and direction. Increment and decrement update every arithmetic flag except carry. Carry keeps the value already stored, and the carry output also shows that stored value.

The block has no state machine. It is the operand path described above, the flag logic, and the status register.

Top module: `alu_flag_gen`

## Requirements
- R1: While `rst_n` is low, `status` reads 16'h0000.
- R2: `op_sel` encodings are 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 INC (adds 1), 5 DEC (subtracts 1); codes 6 and 7 act as ADD. With `wide`=0 only bits 7:0 of the operands are used and `result[15:8]` is 0. With `wide`=1 the 16-bit result wraps modulo 2^16.
- R3: For ADD and ADC, `cf_o` is the carry out of bit 7 (byte) or bit 15 (word). For SUB and SBB it is the borrow. ADC adds `carry_in` and SBB subtracts it; ADD and SUB ignore `carry_in`.
- R4: `af_o` is the carry out of bit 3 for additions, or the borrow into bit 4 for subtractions (INC and DEC included).
- R5: `pf_o` is 1 when `result[7:0]` has an even number of ones, in both widths.
- R6: `zf_o` is 1 when the width-masked result is 0. `sf_o` is bit 7 (byte) or bit 15 (word) of the result.
- R7: `of_o` is 1 when the true signed result is outside the signed range of the selected width.
- R8: For INC and DEC, `cf_o` equals stored `status[0]`, and a flag write leaves `status[0]` unchanged.
- R9: On a rising edge with `flag_we`=1, the flags are stored at CF bit 0, PF bit 2, AF bit 4, ZF bit 6, SF bit 7 and OF bit 11. With `flag_we`=0 they hold. Bits 1, 3, 5 and 15:12 always read 0.
- R10: On a rising edge with `ctrl_we`=1, `ctrl_in[0]`, `ctrl_in[1]` and `ctrl_in[2]` are stored in `status` bits 8 (trap), 9 (interrupt) and 10 (direction). Flag writes never change these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand (unused by INC/DEC) |
| op_sel | input | 3 | Operation code |
| carry_in | input | 1 | Carry/borrow for ADC and SBB |
| wide | input | 1 | 1 = word operation, 0 = byte operation |
| flag_we | input | 1 | Store arithmetic flags on the next edge |
| ctrl_we | input | 1 | Store control bits on the next edge |
| ctrl_in | input | 3 | {direction, interrupt, trap} |
| result | output | 16 | Width-masked result |
| cf_o | output | 1 | Carry flag of the current operation |
| pf_o | output | 1 | Parity flag |
| af_o | output | 1 | Half-carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| status | output | 16 | Stored status word |

## Verification
The result and the six flag outputs are combinational. They are due in the same cycle as the operands, so the monitor compares them 5 ns after the driver changes the inputs on a falling edge. The status word is due on the first rising edge after the write enables are sampled, so the monitor compares it 2 ns after that edge. The carry output of INC and DEC depends on the stored carry bit. Its expected value therefore comes from the bench's own status model as it stood before that edge.

// File: rtl/afg_pkg.sv
package afg_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_INC = 3'd4,
        OP_DEC = 3'd5
    } afg_op_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic par;
        logic aux;
        logic cry;
    } afg_flags_t;

    localparam int POS_CF = 0;
    localparam int POS_PF = 2;
    localparam int POS_AF = 4;
    localparam int POS_ZF = 6;
    localparam int POS_SF = 7;
    localparam int POS_TF = 8;
    localparam int POS_IF = 9;
    localparam int POS_DF = 10;
    localparam int POS_OF = 11;
    localparam int CTRL_W = 3;
endpackage

// File: rtl/afg_addsub.sv
module afg_addsub #(
    parameter int DATA_W = 16
) (
    input  logic              wide,
    input  logic              sub,
    input  logic              cin,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W:0]   raw
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] am;
    logic [DATA_W-1:0] bm;
    logic [DATA_W:0]   cext;

    always_comb begin
        am   = wide ? a : {{HALF_W{1'b0}}, a[HALF_W-1:0]};
        bm   = wide ? b : {{HALF_W{1'b0}}, b[HALF_W-1:0]};
        cext = {{DATA_W{1'b0}}, cin};
        if (sub)
            raw = {1'b0, am} - {1'b0, bm} - cext;
        else
            raw = {1'b0, am} + {1'b0, bm} + cext;
    end
endmodule

// File: rtl/afg_flagcalc.sv
module afg_flagcalc
    import afg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              wide,
    input  logic              sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W:0]   raw,
    output logic [DATA_W-1:0] res,
    output afg_flags_t        fl
);
    localparam int HALF_W  = DATA_W / 2;
    localparam int PAR_W   = 8;
    localparam int NIB_BIT = 4;

    logic sa, sb, sr;

    always_comb begin
        res = wide ? raw[DATA_W-1:0] : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
        sa  = wide ? a[DATA_W-1]   : a[HALF_W-1];
        sb  = wide ? b[DATA_W-1]   : b[HALF_W-1];
        sr  = wide ? res[DATA_W-1] : res[HALF_W-1];

        fl.cry = wide ? raw[DATA_W] : raw[HALF_W];
        fl.aux = a[NIB_BIT] ^ b[NIB_BIT] ^ res[NIB_BIT];
        fl.par = ~^res[PAR_W-1:0];
        fl.zro = (res == '0);
        fl.sgn = sr;
        if (sub)
            fl.ovf = (sa != sb) && (sr != sa);
        else
            fl.ovf = (sa == sb) && (sr != sa);
    end
endmodule

// File: rtl/afg_status_reg.sv
module afg_status_reg
    import afg_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_we,
    input  logic              keep_cf,
    input  afg_flags_t        fl,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            if (flag_we) begin
                if (!keep_cf)
                    stat_q[POS_CF] <= fl.cry;
                stat_q[POS_PF] <= fl.par;
                stat_q[POS_AF] <= fl.aux;
                stat_q[POS_ZF] <= fl.zro;
                stat_q[POS_SF] <= fl.sgn;
                stat_q[POS_OF] <= fl.ovf;
            end
            if (ctrl_we) begin
                stat_q[POS_TF] <= ctrl_in[0];
                stat_q[POS_IF] <= ctrl_in[1];
                stat_q[POS_DF] <= ctrl_in[2];
            end
        end
    end

    assign status = stat_q;
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import afg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [2:0]        op_sel,
    input  logic              carry_in,
    input  logic              wide,
    input  logic              flag_we,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [DATA_W-1:0] result,
    output logic              cf_o,
    output logic              pf_o,
    output logic              af_o,
    output logic              zf_o,
    output logic              sf_o,
    output logic              of_o,
    output logic [STAT_W-1:0] status
);
    logic              is_sub;
    logic              keep_cf;
    logic              cin_eff;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   raw;
    afg_flags_t        fl;

    always_comb begin
        is_sub  = 1'b0;
        keep_cf = 1'b0;
        cin_eff = 1'b0;
        b_eff   = op_b;
        case (op_sel)
            OP_ADC: cin_eff = carry_in;
            OP_SUB: is_sub = 1'b1;
            OP_SBB: begin
                is_sub  = 1'b1;
                cin_eff = carry_in;
            end
            OP_INC: begin
                keep_cf = 1'b1;
                b_eff   = DATA_W'(1);
            end
            OP_DEC: begin
                is_sub  = 1'b1;
                keep_cf = 1'b1;
                b_eff   = DATA_W'(1);
            end
            default: ;
        endcase
    end

    afg_addsub #(.DATA_W(DATA_W)) u_addsub (
        .wide (wide),
        .sub  (is_sub),
        .cin  (cin_eff),
        .a    (op_a),
        .b    (b_eff),
        .raw  (raw)
    );

    afg_flagcalc #(.DATA_W(DATA_W)) u_flags (
        .wide (wide),
        .sub  (is_sub),
        .a    (op_a),
        .b    (b_eff),
        .raw  (raw),
        .res  (result),
        .fl   (fl)
    );

    afg_status_reg #(.STAT_W(STAT_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_we (flag_we),
        .keep_cf (keep_cf),
        .fl      (fl),
        .ctrl_we (ctrl_we),
        .ctrl_in (ctrl_in),
        .status  (status)
    );

    assign cf_o = keep_cf ? status[POS_CF] : fl.cry;
    assign pf_o = fl.par;
    assign af_o = fl.aux;
    assign zf_o = fl.zro;
    assign sf_o = fl.sgn;
    assign of_o = fl.ovf;
endmodule

// File: rtl/afg_checker.sv
module afg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wide,
    input logic [2:0]  op_sel,
    input logic        flag_we,
    input logic        ctrl_we,
    input logic [15:0] result,
    input logic [15:0] status
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> status == 16'h0000);

    assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> result[15:8] == 8'h00);

    assert_zero_flag_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> status[6] == ($past(result) == 16'h0000));

    assert_incdec_keeps_cf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (op_sel == 3'd4 || op_sel == 3'd5)) |=> status[0] == $past(status[0]));

    assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we && !ctrl_we) |=> $stable(status));

    assert_unused_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status[15:12] == 4'h0 && status[5] == 1'b0 && status[3] == 1'b0 && status[1] == 1'b0);

    assert_ctrl_untouched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> status[10:8] == $past(status[10:8]));
endmodule

bind alu_flag_gen afg_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wide    (wide),
    .op_sel  (op_sel),
    .flag_we (flag_we),
    .ctrl_we (ctrl_we),
    .result  (result),
    .status  (status)
);

// File: tb/alu_flag_gen_tb.sv
module alu_flag_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [2:0]  op_sel = '0;
    logic        carry_in = 1'b0;
    logic        wide = 1'b0;
    logic        flag_we = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [2:0]  ctrl_in = '0;
    logic [15:0] result;
    logic        cf_o, pf_o, af_o, zf_o, sf_o, of_o;
    logic [15:0] status;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [15:0] res;
        logic [5:0]  fl;   // {of, sf, zf, pf, af, cf}
        logic [15:0] st;
        string       req;
    } item_t;

    item_t       sb_q[$];
    logic [15:0] exp_stat = '0;

    always #10 clk = ~clk;

    alu_flag_gen u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .carry_in(carry_in), .wide(wide), .flag_we(flag_we), .ctrl_we(ctrl_we),
        .ctrl_in(ctrl_in), .result(result), .cf_o(cf_o), .pf_o(pf_o), .af_o(af_o),
        .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o), .status(status)
    );

    task automatic model(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic cin, input logic wd, input logic held_cf,
                         output logic [15:0] r, output logic [5:0] fl);
        int w, mx, ua, ub, c, t, sa, sbv, st, na, nb, nt;
        bit sub, kc;
        w  = wd ? 16 : 8;
        mx = 1 << w;
        ua = int'(a) & (mx - 1);
        ub = int'(b) & (mx - 1);
        c = 0; sub = 0; kc = 0;
        case (op)
            3'd1: c = int'(cin);
            3'd2: sub = 1;
            3'd3: begin sub = 1; c = int'(cin); end
            3'd4: begin ub = 1; kc = 1; end
            3'd5: begin ub = 1; kc = 1; sub = 1; end
            default: ;
        endcase
        t  = sub ? ua - ub - c : ua + ub + c;
        na = ua & 15; nb = ub & 15;
        nt = sub ? na - nb - c : na + nb + c;
        sa  = (ua >= mx / 2) ? ua - mx : ua;
        sbv = (ub >= mx / 2) ? ub - mx : ub;
        st  = sub ? sa - sbv - c : sa + sbv + c;
        r = 16'(t & (mx - 1));
        fl[0] = kc ? held_cf : (sub ? (t < 0) : (t >= mx));
        fl[1] = sub ? (nt < 0) : (nt > 15);
        fl[2] = ($countones(r[7:0]) % 2) == 0;
        fl[3] = (r == 16'h0);
        fl[4] = wd ? r[15] : r[7];
        fl[5] = (st < -(mx / 2)) || (st > mx / 2 - 1);
    endtask

    task automatic drive(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic cin, input logic wd, input logic fwe,
                         input logic cwe, input logic [2:0] cin3, input string req);
        item_t it;
        logic [15:0] r;
        logic [5:0]  fl;
        model(op, a, b, cin, wd, exp_stat[0], r, fl);
        if (fwe) begin
            exp_stat[0]  = fl[0];
            exp_stat[2]  = fl[2];
            exp_stat[4]  = fl[1];
            exp_stat[6]  = fl[3];
            exp_stat[7]  = fl[4];
            exp_stat[11] = fl[5];
        end
        if (cwe) exp_stat[10:8] = {cin3[2], cin3[1], cin3[0]};
        @(negedge clk);
        op_sel = op; op_a = a; op_b = b; carry_in = cin; wide = wd;
        flag_we = fwe; ctrl_we = cwe; ctrl_in = cin3;
        it.res = r; it.fl = fl; it.st = exp_stat; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        flag_we = 1'b0; ctrl_we = 1'b0;
    endtask

    // monitor
    initial begin
        item_t it;
        logic [5:0] got;
        forever begin
            @(negedge clk);
            #5;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                got = {of_o, sf_o, zf_o, pf_o, af_o, cf_o};
                n_checks++;
                if (result !== it.res || got !== it.fl) begin
                    n_fail++;
                    $display("FAIL %s: result/flags got %h/%b expected %h/%b",
                             it.req, result, got, it.res, it.fl);
                end
                @(posedge clk);
                #2;
                n_checks++;
                if (status !== it.st) begin
                    n_fail++;
                    $display("FAIL %s: status got %h expected %h", it.req, status, it.st);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (status !== 16'h0000) begin
            n_fail++;
            $display("FAIL R1: status in reset got %h expected 0000", status);
        end
        rst_n = 1'b1;
        // R3 R4 R6 R7: byte 7F+01 and FF+01
        drive(3'd0, 16'h007F, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R7 byte add overflow");
        drive(3'd0, 16'h00FF, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R3 byte carry/zero");
        // R2: ignored upper bits in byte mode
        drive(3'd0, 16'hAB12, 16'hCD34, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R2 byte masks upper");
        // word corners
        drive(3'd0, 16'h7FFF, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, "R7 word add overflow");
        drive(3'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, "R6 word carry zero");
        // R3: carry_in ignored by ADD, used by ADC
        drive(3'd0, 16'h1234, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, "R3 add ignores carry_in");
        drive(3'd1, 16'h00FE, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, "R3 adc with carry");
        // subtraction
        drive(3'd2, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R4 byte borrow");
        drive(3'd2, 16'h8000, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, "R7 word sub overflow");
        drive(3'd3, 16'h0010, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, "R3 sbb borrow in");
        drive(3'd2, 16'h0005, 16'h0005, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, "R3 sub ignores carry_in");
        // R5: parity only from low byte
        drive(3'd0, 16'h0300, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, "R5 parity low byte");
        drive(3'd0, 16'h0007, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, "R5 parity odd");
        // R8: set CF, then INC/DEC keep it
        drive(3'd0, 16'h00FF, 16'h0002, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R3 set carry");
        drive(3'd4, 16'h00FF, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R8 inc keeps cf=1");
        drive(3'd2, 16'h0002, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R3 clear carry");
        drive(3'd5, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, "R8 dec keeps cf=0");
        drive(3'd4, 16'h7FFF, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, "R8 inc word overflow");
        // R2: code 6 and 7 act as add
        drive(3'd6, 16'h0101, 16'h0202, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, "R2 code 6 adds");
        drive(3'd7, 16'h00F0, 16'h0020, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, "R2 code 7 adds");
        // R9: no write leaves status held
        drive(3'd0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, "R9 no write holds");
        // R10: control bits
        drive(3'd0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 3'b101, "R10 ctrl load");
        drive(3'd0, 16'h8000, 16'h8000, 1'b0, 1'b1, 1'b1, 1'b0, 3'b010, "R10 flag write keeps ctrl");
        drive(3'd0, 16'h0001, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b1, 3'b010, "R10 ctrl and flags together");
        idle();
        // random sweep
        for (int i = 0; i < 400; i++) begin
            drive(3'($urandom % 8), 16'($urandom), 16'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom % 4 == 0), 3'($urandom),
                  "R2 random");
        end
        idle();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule